// File: doc/BRIEF.md
# Fair/Urgent Arbitration Gate

This block sits in each node on a shared serial backplane. It decides whether the node may enter the next arbitration contest. It also supplies the key that the node presents in that contest.

A node runs in one of two classes:

- A fair-class node holds a single enable flag. The flag drops once the node has won the bus and sent its own fair packet. It comes back only at the next arbitration reset gap.
- An urgent-class node holds a small credit counter. Every fair packet seen on the bus refills the counter, whoever sent that packet. Every urgent packet seen on the bus uses up one credit. The node may contend only while it has credit left.

The contest key places a 4-bit level above the node's Physical_ID. A fair node always presents level 0, so any urgent node outranks every fair node. Among nodes at the same level, the higher Physical_ID wins.

Acknowledges are handled separately and need no contest. When a response is pending and the acknowledge gap is seen, the block signals the start of the acknowledge, beginning with its data prefix. The line drivers, the packet coding and the wired comparison between nodes are handled outside this block.

Top module: `arb_gate`

## Requirements
- R1: A fair packet event (`pkt_fair`=1, from any node) loads the urgent credit counter with 3.
- R2: An urgent packet event (`pkt_urgent`=1, from any node) lowers the credit counter by one, and the counter stays at 0 instead of wrapping. If a fair and an urgent event arrive in the same cycle, the credit counter is loaded with 3.
- R3: An arbitration reset gap (`arb_gap`=1) loads the credit counter with 3 and sets the fair enable flag. It takes precedence over any packet event in the same cycle.
- R4: In fair class (`urgent_mode`=0), a fair packet event sent by this node (`pkt_own`=1) clears the enable flag. The flag stays clear through all other packet events until the next arbitration reset gap.
- R5: In urgent class (`urgent_mode`=1), the node is eligible only while the credit counter is nonzero. In fair class, the node is eligible only while the enable flag is set.
- R6: `arb_req` is registered. After each clock edge it equals `req` AND eligibility, both taken from before that edge.
- R7: `prio_key` is combinational and equals {level field, `phy_id`}, with the level field in bits 9:6. A fair node presents level 0. An urgent node presents `level`, raised to 1 when `level` is 0.
- R8: `ack_start` pulses high for exactly one cycle, on the edge after a cycle in which `ack_gap` and `ack_pending` are both 1. `ack_start` does not depend on `req` or on eligibility, and it never raises `arb_req`.
- R9: After power reset, `arb_req` and `ack_start` are 0, the credit counter is 3 and the enable flag is set. No bus-reset output exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power reset |
| req | input | 1 | Node wants the bus |
| urgent_mode | input | 1 | 1 = urgent class, 0 = fair class |
| level | input | 4 | Urgent priority level |
| phy_id | input | 6 | Physical_ID of this node |
| pkt_fair | input | 1 | Pulse: fair packet seen on the bus |
| pkt_urgent | input | 1 | Pulse: urgent packet seen on the bus |
| pkt_own | input | 1 | The packet in this cycle was sent by this node |
| arb_gap | input | 1 | Pulse: arbitration reset gap seen |
| ack_gap | input | 1 | Pulse: acknowledge gap seen |
| ack_pending | input | 1 | A received packet awaits an acknowledge |
| arb_req | output | 1 | Registered request to enter arbitration |
| prio_key | output | 10 | Contest key {level, phy_id} |
| ack_start | output | 1 | Start of acknowledge (data prefix) |

## Verification
The bench builds the block with its default parameters: 3 credits, a 4-bit level and a 6-bit Physical_ID. The 3-credit setting lets a short run of urgent packets reach zero credit and then press against the saturation floor. With the 10-bit key, each of the three level cases can be checked as an exact value: a fair node, an urgent node with a nonzero level, and an urgent node with level 0. The vector walk also places competing events in one cycle: a gap together with a packet, and a fair event together with an urgent one. These cases reach the precedence rules directly.

// File: rtl/arb_gate.sv
module arb_gate #(
  parameter int ID_W    = 6,
  parameter int LVL_W   = 4,
  parameter int CREDITS = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req,
  input  logic                   urgent_mode,
  input  logic [LVL_W-1:0]       level,
  input  logic [ID_W-1:0]        phy_id,
  input  logic                   pkt_fair,
  input  logic                   pkt_urgent,
  input  logic                   pkt_own,
  input  logic                   arb_gap,
  input  logic                   ack_gap,
  input  logic                   ack_pending,
  output logic                   arb_req,
  output logic [LVL_W+ID_W-1:0]  prio_key,
  output logic                   ack_start
);
  localparam int CNT_W = $clog2(CREDITS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(CREDITS);

  logic [CNT_W-1:0] credit;
  logic             arb_en;
  logic             eligible;
  logic [LVL_W-1:0] lvl_eff;

  assign eligible = urgent_mode ? (credit != '0) : arb_en;
  assign lvl_eff  = !urgent_mode ? '0 : (level == '0) ? LVL_W'(1) : level;
  assign prio_key = {lvl_eff, phy_id};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      credit <= FULL;
    end else if (arb_gap || pkt_fair) begin
      credit <= FULL;
    end else if (pkt_urgent && credit != '0) begin
      credit <= credit - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_en <= 1'b1;
    end else if (arb_gap) begin
      arb_en <= 1'b1;
    end else if (!urgent_mode && pkt_fair && pkt_own) begin
      arb_en <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arb_req   <= 1'b0;
      ack_start <= 1'b0;
    end else begin
      arb_req   <= req && eligible;
      ack_start <= ack_gap && ack_pending;
    end
  end
endmodule

// File: rtl/arb_gate_chk.sv
module arb_gate_chk #(
  parameter int CNT_W = 2,
  parameter int CREDITS = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req,
  input logic             urgent_mode,
  input logic             pkt_fair,
  input logic             pkt_own,
  input logic             arb_gap,
  input logic             ack_gap,
  input logic             ack_pending,
  input logic             arb_req,
  input logic             ack_start,
  input logic [CNT_W-1:0] credit,
  input logic             arb_en
);
  p_req_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arb_req |-> $past(req));

  p_ack_follows_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_gap && ack_pending) |=> ack_start);

  p_ack_has_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack_start |-> $past(ack_gap && ack_pending));

  p_gap_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    arb_gap |=> (credit == CNT_W'(CREDITS) && arb_en));

  p_own_win_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!urgent_mode && pkt_fair && pkt_own && !arb_gap) |=> !arb_en);

  p_no_credit_no_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (urgent_mode && credit == '0) |=> !arb_req);
endmodule

bind arb_gate arb_gate_chk #(.CNT_W(CNT_W), .CREDITS(CREDITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .urgent_mode(urgent_mode),
  .pkt_fair(pkt_fair), .pkt_own(pkt_own), .arb_gap(arb_gap),
  .ack_gap(ack_gap), .ack_pending(ack_pending), .arb_req(arb_req),
  .ack_start(ack_start), .credit(credit), .arb_en(arb_en)
);

// File: tb/arb_gate_test.sv
module arb_gate_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0, urgent_mode = 1'b0;
  logic [3:0] level = 4'd6;
  logic [5:0] phy_id = 6'd33;
  logic       pkt_fair = 1'b0, pkt_urgent = 1'b0, pkt_own = 1'b0;
  logic       arb_gap = 1'b0, ack_gap = 1'b0, ack_pending = 1'b0;
  logic       arb_req, ack_start;
  logic [9:0] prio_key;
  int         n_run = 0, n_fail = 0;
  bit         done = 1'b0;

  always #10ns clk = ~clk;

  arb_gate uut (
    .clk(clk), .rst_n(rst_n), .req(req), .urgent_mode(urgent_mode),
    .level(level), .phy_id(phy_id), .pkt_fair(pkt_fair),
    .pkt_urgent(pkt_urgent), .pkt_own(pkt_own), .arb_gap(arb_gap),
    .ack_gap(ack_gap), .ack_pending(ack_pending), .arb_req(arb_req),
    .prio_key(prio_key), .ack_start(ack_start)
  );

  // {urgent_mode, pkt_fair, pkt_urgent, pkt_own, arb_gap, expected arb_req}
  localparam bit [5:0] VEC [0:17] = '{
    6'b101001, 6'b101001, 6'b101000, 6'b101000, 6'b110001, 6'b111001,
    6'b101001, 6'b101001, 6'b101000, 6'b101011, 6'b010001, 6'b001001,
    6'b010100, 6'b010000, 6'b001100, 6'b000011, 6'b010111, 6'b100001
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drop_all();
    pkt_fair = 0; pkt_urgent = 0; pkt_own = 0; arb_gap = 0;
    ack_gap = 0; ack_pending = 0;
  endtask

  initial begin
    #(20ns * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 arb_req in reset", arb_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 arb_req after reset", arb_req, 0);
    check("R9 ack_start after reset", ack_start, 0);
    req = 1'b1; urgent_mode = 1'b1;
    @(negedge clk);
    check("R9 credit full after reset", arb_req, 1);

    for (int i = 0; i < 18; i++) begin
      urgent_mode = VEC[i][5]; pkt_fair = VEC[i][4]; pkt_urgent = VEC[i][3];
      pkt_own = VEC[i][2]; arb_gap = VEC[i][1];
      @(negedge clk);
      drop_all();
      @(negedge clk);
      check($sformatf("R1/R2/R3/R4/R5/R6 vector %0d", i), arb_req, VEC[i][0]);
      check($sformatf("R7 key vector %0d", i), prio_key,
            {(VEC[i][5] ? 4'd6 : 4'd0), 6'd33});
    end

    // R6: request withdrawn
    req = 1'b0;
    @(negedge clk);
    check("R6 req low", arb_req, 0);
    req = 1'b1;
    @(negedge clk);
    check("R6 req high", arb_req, 1);

    // R7 key variants
    urgent_mode = 1'b1; level = 4'd9; phy_id = 6'd45; #1ns;
    check("R7 urgent level 9", prio_key, {4'd9, 6'd45});
    level = 4'd0; #1ns;
    check("R7 urgent level 0 raised", prio_key, {4'd1, 6'd45});
    urgent_mode = 1'b0; level = 4'd15; #1ns;
    check("R7 fair level 0", prio_key, {4'd0, 6'd45});

    // R8 immediate acknowledge
    req = 1'b0;
    @(negedge clk);
    ack_gap = 1; ack_pending = 1;
    @(negedge clk);
    drop_all();
    check("R8 ack_start pulse", ack_start, 1);
    check("R8 no arb_req for ack", arb_req, 0);
    @(negedge clk);
    check("R8 ack_start one cycle", ack_start, 0);
    ack_gap = 1; ack_pending = 0;
    @(negedge clk);
    drop_all();
    check("R8 gap without pending", ack_start, 0);

    // R9 mid-run reset restores defaults
    urgent_mode = 1'b0; req = 1'b1; pkt_fair = 1; pkt_own = 1;
    @(negedge clk);
    drop_all();
    @(negedge clk);
    check("R4 own fair packet clears", arb_req, 0);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9 reset clears arb_req", arb_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 enable restored", arb_req, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule